// File: doc/BRIEF.md
# DRAM Manual Command Issuer

This block gives software a way to place single commands on a DRAM command bus during bring-up. The interface is one 32-bit command word. Writing a word whose top bit is set, while the block is idle, captures the word's fields: a rank mask, a bank number, a 13-bit address and a 4-bit command code. On the next cycle the block drives that command onto the bus. It then holds its busy flag, which is the start bit of the readback word, for a programmable number of cycles chosen by the command type. When that time has passed, the start bit reads back as zero. Software polls the start bit to learn that the command has finished and that the next one may be written.

The wait counts come from a packed configuration bus that holds one slot per timed command. Typical values are the mode-register delay, the refresh cycle time and the long ZQ calibration time. The chip selects, row and column strobes, write enable, bank lines and address lines are all registered. One extra registered output drives the memory's reset line low for the reset-low command.

Top module: `dram_cmd_issuer`

## Requirements
- R1: While the synchronous reset is held and after it is released, the readback word is zero, every chip select is high, the row strobe, column strobe and write enable are high, the bank and address lines are zero, and the memory reset output is high.
- R2: A write is accepted when wr_en is high, bit 31 of the word is 1, the block is idle and the code is valid. An accepted write sets readback bit 31 from the next cycle. It also returns the captured fields at rank mask bits 21:20, bank bits 19:17, address bits 16:4 and code bits 3:0, with every other bit zero.
- R3: In the cycle after an accepted write, cs_n[i] is low for each set bit i of the rank mask (value 3 selects both ranks). The selects return high on the following cycle.
- R4: The strobes (ras_n, cas_n, we_n) are driven per code: 1 precharge-all gives 0,1,0 with address bit 10 high; 2 refresh gives 0,0,1; 3 mode-register-set gives 0,0,0; 4 ZQ short gives 1,1,0 with address bit 10 low; 5 ZQ long gives 1,1,0 with address bit 10 high; 8 mode-register-read gives 1,0,1.
- R5: For mode-register-set and mode-register-read, the bank lines carry the bank field and the address lines carry the address field unchanged, including bit 8, which requests a DLL reset. For every other code the bank lines are zero and the address is zero apart from bit 10 as set by R4.
- R6: Readback bit 31 falls exactly W+1 cycles after the accepting clock edge. W is the wait slot of the command: slot 0 precharge-all, 1 refresh, 2 mode-register-set, 3 ZQ short, 4 ZQ long, 5 reset-low, 6 mode-register-read. Each slot is WAIT_W bits, with slot n at bits n*WAIT_W upward.
- R7: Code 0 (deselect) keeps all chip selects high and the strobes high, and keeps bit 31 set for exactly one cycle.
- R8: Codes 7 and 9 to 15 are reserved. A write with a reserved code never sets bit 31, leaves the readback fields unchanged and drives nothing on the bus.
- R9: A write that arrives while bit 31 is set is ignored: no new command appears on the bus, and the readback fields keep the running command.
- R10: A write with bit 31 clear is ignored: the readback word and the bus are unchanged.
- R11: Code 6 (reset-low) keeps all chip selects high and drives dram_reset_n low from the cycle after acceptance until the cycle in which bit 31 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word being written |
| wait_cfg | input | 7*WAIT_W | Packed per-command wait counts, slot n at n*WAIT_W |
| rd_data | output | 32 | Readback: busy at bit 31 plus captured fields |
| cs_n | output | RANKS | Chip selects, active low, one per rank |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank lines |
| addr | output | 13 | Address lines |
| dram_reset_n | output | 1 | Memory reset, active low |

## Verification
The command word is captured at clock edge k. Both the bus pins and the rising start bit appear one register later, so the bench samples them on the falling edge that follows edge k. The bench then expects idle pins on the next falling edge. It counts falling edges until the start bit drops and compares that count with the configured wait plus one. The same count is used to check how long the reset line stays low and how long a second write is held off. Ignored writes are judged on the falling edge right after the edge that would have taken them: at that point the bench compares the bus and the full readback word with their previous values.

// File: rtl/dci_pkg.sv
// Package dci_pkg
// Shared field positions, command codes and wait-slot numbering for the
// DRAM manual command issuer. Assumes a 32-bit command word.
package dci_pkg;

    localparam int WORD_W    = 32;
    localparam int START_BIT = 31;
    localparam int RANK_LSB  = 20;
    localparam int BANK_LSB  = 17;
    localparam int BANK_W    = 3;
    localparam int ADDR_LSB  = 4;
    localparam int ADDR_W    = 13;
    localparam int CODE_W    = 4;
    localparam int NUM_SLOTS = 7;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef enum logic [CODE_W-1:0] {
        OP_DESEL = 4'd0,
        OP_PREA  = 4'd1,
        OP_REF   = 4'd2,
        OP_MRS   = 4'd3,
        OP_ZQS   = 4'd4,
        OP_ZQL   = 4'd5,
        OP_RSTL  = 4'd6,
        OP_MRR   = 4'd8
    } op_code_e;

    localparam logic [SLOT_W-1:0] SLOT_PREA = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_REF  = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_MRS  = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_ZQS  = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_ZQL  = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_RSTL = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_MRR  = 3'd6;

endpackage

// File: rtl/dci_cmd_decode.sv
// Module dci_cmd_decode
// Pure combinational decode of a 4-bit command code into pin levels,
// operand routing, wait slot and validity. Reserved codes give valid=0.
module dci_cmd_decode
    import dci_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output logic              drives_bus,
    output logic              pass_operands,
    output logic              a10,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              has_wait,
    output logic [SLOT_W-1:0] slot,
    output logic              is_rstl
);

    // Map each code to its bus pattern and timing slot
    always_comb begin
        valid         = 1'b1;
        drives_bus    = 1'b1;
        pass_operands = 1'b0;
        a10           = 1'b0;
        ras_n         = 1'b1;
        cas_n         = 1'b1;
        we_n          = 1'b1;
        has_wait      = 1'b1;
        slot          = SLOT_PREA;
        is_rstl       = 1'b0;
        case (code)
            OP_DESEL: begin
                drives_bus = 1'b0;
                has_wait   = 1'b0;
            end
            OP_PREA: begin
                ras_n = 1'b0; we_n = 1'b0; a10 = 1'b1;
                slot  = SLOT_PREA;
            end
            OP_REF: begin
                ras_n = 1'b0; cas_n = 1'b0;
                slot  = SLOT_REF;
            end
            OP_MRS: begin
                ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
                pass_operands = 1'b1;
                slot  = SLOT_MRS;
            end
            OP_ZQS: begin
                we_n = 1'b0;
                slot = SLOT_ZQS;
            end
            OP_ZQL: begin
                we_n = 1'b0; a10 = 1'b1;
                slot = SLOT_ZQL;
            end
            OP_RSTL: begin
                drives_bus = 1'b0;
                is_rstl    = 1'b1;
                slot       = SLOT_RSTL;
            end
            OP_MRR: begin
                cas_n = 1'b0;
                pass_operands = 1'b1;
                slot  = SLOT_MRR;
            end
            default: begin
                valid      = 1'b0;
                drives_bus = 1'b0;
                has_wait   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dci_wait_timer.sv
// Module dci_wait_timer
// Down-counter loaded with the wait count of the selected slot when a
// command is accepted. Assumes load is only asserted while idle.
module dci_wait_timer
    import dci_pkg::*;
#(
    parameter int WAIT_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        has_wait,
    input  logic [SLOT_W-1:0]           slot,
    input  logic [NUM_SLOTS*WAIT_W-1:0] wait_cfg,
    output logic                        cnt_zero
);

    localparam int TABLE_N = 2 ** SLOT_W;

    logic [WAIT_W-1:0] slot_val [TABLE_N];
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] load_val;

    // Unpack the configuration bus; unused table entries read as zero
    for (genvar g = 0; g < TABLE_N; g++) begin : g_slot
        if (g < NUM_SLOTS) begin : g_used
            assign slot_val[g] = wait_cfg[g*WAIT_W +: WAIT_W];
        end else begin : g_spare
            assign slot_val[g] = '0;
        end
    end

    // Wait value for the command being loaded
    always_comb load_val = has_wait ? slot_val[slot] : '0;

    // Load on accept, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/dci_bus_drive.sv
// Module dci_bus_drive
// Registered command bus. Holds the idle pattern except for the single
// cycle after an issue pulse, when it presents the decoded command.
module dci_bus_drive
    import dci_pkg::*;
#(
    parameter int RANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [RANKS-1:0]  rank_mask,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              pass_operands,
    input  logic              a10,
    input  logic              ras_n_in,
    input  logic              cas_n_in,
    input  logic              we_n_in,
    output logic [RANKS-1:0]  cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1) << 10;

    // Present one command for one cycle, otherwise idle
    always_ff @(posedge clk) begin
        if (!rst_n || !issue) begin
            cs_n  <= '1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ba    <= '0;
            addr  <= '0;
        end else begin
            cs_n  <= ~rank_mask;
            ras_n <= ras_n_in;
            cas_n <= cas_n_in;
            we_n  <= we_n_in;
            ba    <= pass_operands ? bank : '0;
            addr  <= pass_operands ? addr_in : (a10 ? A10_MASK : '0);
        end
    end

endmodule

// File: rtl/dram_cmd_issuer.sv
// Module dram_cmd_issuer
// Accepts a packed command word, issues the command on the DRAM command
// bus, and holds the start bit until the per-command wait elapses.
// Assumes RANKS <= 11 so the rank field fits below the start bit.
module dram_cmd_issuer
    import dci_pkg::*;
#(
    parameter int RANKS  = 2,
    parameter int WAIT_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [NUM_SLOTS*WAIT_W-1:0] wait_cfg,
    output logic [WORD_W-1:0]           rd_data,
    output logic [RANKS-1:0]            cs_n,
    output logic                        ras_n,
    output logic                        cas_n,
    output logic                        we_n,
    output logic [BANK_W-1:0]           ba,
    output logic [ADDR_W-1:0]           addr,
    output logic                        dram_reset_n
);

    logic [RANKS-1:0]  w_rank;
    logic [BANK_W-1:0] w_bank;
    logic [ADDR_W-1:0] w_addr;
    logic [CODE_W-1:0] w_code;

    logic [RANKS-1:0]  rank_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CODE_W-1:0] code_q;
    logic              busy_q;

    logic d_valid, d_bus, d_pass, d_a10, d_ras, d_cas, d_we, d_wait, d_rstl;
    logic [SLOT_W-1:0] d_slot;
    logic accept, cnt_zero, finish;
    logic unused_word_bits;

    // Split the incoming word into its fields
    always_comb begin
        w_rank = wr_data[RANK_LSB +: RANKS];
        w_bank = wr_data[BANK_LSB +: BANK_W];
        w_addr = wr_data[ADDR_LSB +: ADDR_W];
        w_code = wr_data[CODE_W-1:0];
    end
    assign unused_word_bits = ^wr_data[START_BIT-1:RANK_LSB+RANKS];

    dci_cmd_decode u_decode (
        .code          (w_code),
        .valid         (d_valid),
        .drives_bus    (d_bus),
        .pass_operands (d_pass),
        .a10           (d_a10),
        .ras_n         (d_ras),
        .cas_n         (d_cas),
        .we_n          (d_we),
        .has_wait      (d_wait),
        .slot          (d_slot),
        .is_rstl       (d_rstl)
    );

    assign accept = wr_en && wr_data[START_BIT] && !busy_q && d_valid;
    assign finish = busy_q && cnt_zero;

    dci_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .has_wait (d_wait),
        .slot     (d_slot),
        .wait_cfg (wait_cfg),
        .cnt_zero (cnt_zero)
    );

    dci_bus_drive #(.RANKS(RANKS)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue         (accept && d_bus),
        .rank_mask     (w_rank),
        .bank          (w_bank),
        .addr_in       (w_addr),
        .pass_operands (d_pass),
        .a10           (d_a10),
        .ras_n_in      (d_ras),
        .cas_n_in      (d_cas),
        .we_n_in       (d_we),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .ba            (ba),
        .addr          (addr)
    );

    // Capture fields of an accepted command for readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
            bank_q <= '0;
            addr_q <= '0;
            code_q <= '0;
        end else if (accept) begin
            rank_q <= w_rank;
            bank_q <= w_bank;
            addr_q <= w_addr;
            code_q <= w_code;
        end
    end

    // Start bit: set on accept, cleared when the wait has run out
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (accept) busy_q <= 1'b1;
        else if (finish) busy_q <= 1'b0;
    end

    // Memory reset line held low for the duration of a reset-low command
    always_ff @(posedge clk) begin
        if (!rst_n)                 dram_reset_n <= 1'b1;
        else if (accept && d_rstl)  dram_reset_n <= 1'b0;
        else if (finish)            dram_reset_n <= 1'b1;
    end

    // Assemble the readback word
    always_comb begin
        rd_data                          = '0;
        rd_data[START_BIT]               = busy_q;
        rd_data[RANK_LSB +: RANKS]       = rank_q;
        rd_data[BANK_LSB +: BANK_W]      = bank_q;
        rd_data[ADDR_LSB +: ADDR_W]      = addr_q;
        rd_data[CODE_W-1:0]              = code_q;
    end

endmodule

// File: rtl/dci_checker.sv
// Module dci_checker
// Temporal checks on the issuer's ports; bound to every dram_cmd_issuer.
module dci_checker #(
    parameter int RANKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_start,
    input logic [3:0]       wr_code,
    input logic [31:0]      rd_data,
    input logic [RANKS-1:0] cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dram_reset_n
);

    // R3
    cs_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |=> (cs_n == '1));

    // R3
    cs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> $past(wr_en && wr_start && !rd_data[31]));

    // R4
    cmd_not_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> !(ras_n && cas_n && we_n));

    // R9
    busy_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] |=> $stable(rd_data[30:0]));

    // R11
    reset_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_reset_n |-> rd_data[31]);

    // R8
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_start && !rd_data[31] && (wr_code == 4'd7 || wr_code > 4'd8))
        |=> !rd_data[31]);

    // R10
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_start && !rd_data[31]) |=> $stable(rd_data));

endmodule

bind dram_cmd_issuer dci_checker #(.RANKS(RANKS)) u_dci_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_start     (wr_data[31]),
    .wr_code      (wr_data[3:0]),
    .rd_data      (rd_data),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .dram_reset_n (dram_reset_n)
);

// File: tb/dram_cmd_issuer_bench.sv
module dram_cmd_issuer_bench;

    localparam int RANKS  = 2;
    localparam int WAIT_W = 10;
    localparam int NSLOT  = 7;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en = 1'b0;
    logic [31:0]             wr_data = '0;
    logic [NSLOT*WAIT_W-1:0] wait_cfg;
    logic [31:0]             rd_data;
    logic [RANKS-1:0]        cs_n;
    logic                    ras_n, cas_n, we_n;
    logic [2:0]              ba;
    logic [12:0]             addr;
    logic                    dram_reset_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    dram_cmd_issuer #(.RANKS(RANKS), .WAIT_W(WAIT_W)) u_dram_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wait_cfg(wait_cfg), .rd_data(rd_data), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .dram_reset_n(dram_reset_n)
    );

    // Wait counts: prea 2, ref 5, mrs 3, zqs 4, zql 6, rstl 3, mrr 1
    initial begin
        wait_cfg = '0;
        wait_cfg[0*WAIT_W +: WAIT_W] = 10'd2;
        wait_cfg[1*WAIT_W +: WAIT_W] = 10'd5;
        wait_cfg[2*WAIT_W +: WAIT_W] = 10'd3;
        wait_cfg[3*WAIT_W +: WAIT_W] = 10'd4;
        wait_cfg[4*WAIT_W +: WAIT_W] = 10'd6;
        wait_cfg[5*WAIT_W +: WAIT_W] = 10'd3;
        wait_cfg[6*WAIT_W +: WAIT_W] = 10'd1;
    end

    typedef struct packed {
        logic [1:0]  rank;
        logic [2:0]  bank;
        logic [12:0] adr;
        logic [3:0]  code;
        logic [1:0]  e_cs;
        logic [2:0]  e_ctl;
        logic [2:0]  e_ba;
        logic [12:0] e_adr;
        logic [7:0]  e_wait;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 3'd2, 13'h0042, 4'd3, 2'b00, 3'b000, 3'd2, 13'h0042, 8'd3},
        '{2'd1, 3'd0, 13'h0120, 4'd3, 2'b10, 3'b000, 3'd0, 13'h0120, 8'd3},
        '{2'd3, 3'd5, 13'h00AB, 4'd1, 2'b00, 3'b010, 3'd0, 13'h0400, 8'd2},
        '{2'd2, 3'd7, 13'h0000, 4'd2, 2'b01, 3'b001, 3'd0, 13'h0000, 8'd5},
        '{2'd3, 3'd0, 13'h1FFF, 4'd5, 2'b00, 3'b110, 3'd0, 13'h0400, 8'd6},
        '{2'd1, 3'd3, 13'h00FF, 4'd4, 2'b10, 3'b110, 3'd0, 13'h0000, 8'd4},
        '{2'd1, 3'd1, 13'h0005, 4'd8, 2'b10, 3'b101, 3'd1, 13'h0005, 8'd1},
        '{2'd3, 3'd0, 13'h0000, 4'd0, 2'b11, 3'b111, 3'd0, 13'h0000, 8'd0}
    };

    function automatic logic [31:0] fields(logic [1:0] r, logic [2:0] b,
                                           logic [12:0] a, logic [3:0] c);
        return (32'(r) << 20) | (32'(b) << 17) | (32'(a) << 4) | 32'(c);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(string req);
        chk(req, "cs_n idle", 32'(cs_n), 32'(2'b11));
        chk(req, "strobes idle", 32'({ras_n, cas_n, we_n}), 32'(3'b111));
    endtask

    // Count falling edges until the start bit drops; check bus idle meanwhile
    task automatic wait_done(output int n, output int cs_seen);
        n = 0; cs_seen = 0;
        while (rd_data[31] && n < 400) begin
            @(negedge clk);
            n++;
            if (cs_n != 2'b11) cs_seen++;
        end
    endtask

    initial begin
        int n, cs_seen;
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "readback", rd_data, 32'h0);
        chk_idle("R1");
        chk("R1", "ba/addr", 32'({ba, addr}), 32'h0);
        chk("R1", "dram_reset_n", 32'(dram_reset_n), 32'h1);

        // Vector table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = 32'h8000_0000 | fields(v.rank, v.bank, v.adr, v.code);
            @(negedge clk);
            wr_en = 1'b0;
            chk("R3", "cs_n", 32'(cs_n), 32'(v.e_cs));
            chk("R4", "ras/cas/we", 32'({ras_n, cas_n, we_n}), 32'(v.e_ctl));
            chk("R5", "ba", 32'(ba), 32'(v.e_ba));
            chk("R5", "addr", 32'(addr), 32'(v.e_adr));
            chk("R2", "readback busy", rd_data,
                32'h8000_0000 | fields(v.rank, v.bank, v.adr, v.code));
            wait_done(n, cs_seen);
            if (v.code == 4'd0) chk("R7", "deselect busy cycles", 32'(n), 32'd1);
            else                chk("R6", "busy cycles", 32'(n), 32'(v.e_wait) + 32'd1);
            chk("R3", "cs pulse width", 32'(cs_seen), 32'd0);
            chk("R2", "readback done", rd_data, fields(v.rank, v.bank, v.adr, v.code));
        end

        // R11: reset-low command
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8000_0000 | fields(2'd3, 3'd0, 13'h0, 4'd6);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11", "reset low", 32'(dram_reset_n), 32'h0);
        chk_idle("R11");
        n = 0;
        while (rd_data[31] && n < 400) begin
            chk("R11", "reset held", 32'(dram_reset_n), 32'h0);
            @(negedge clk);
            n++;
        end
        chk("R11", "duration", 32'(n), 32'd4);
        chk("R11", "reset released", 32'(dram_reset_n), 32'h1);

        // R8: reserved codes
        foreach (VECS[i]) begin end
        prev = rd_data;
        for (int c = 7; c < 16; c += 5) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = 32'h8000_0000 | fields(2'd3, 3'd4, 13'h0123, 4'(c));
            @(negedge clk);
            wr_en = 1'b0;
            chk("R8", "readback", rd_data, prev);
            chk_idle("R8");
        end

        // R10: start bit clear
        @(negedge clk);
        wr_en = 1'b1; wr_data = fields(2'd3, 3'd1, 13'h0077, 4'd3);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10", "readback", rd_data, prev);
        chk_idle("R10");

        // R9: write during a running refresh
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h8000_0000 | fields(2'd3, 3'd0, 13'h0, 4'd2);
        @(negedge clk);
        wr_data = 32'h8000_0000 | fields(2'd1, 3'd2, 13'h0042, 4'd3);
        @(negedge clk);
        wr_en = 1'b0;
        chk_idle("R9");
        chk("R9", "still busy", 32'(rd_data[31]), 32'h1);
        wait_done(n, cs_seen);
        chk("R9", "busy cycles", 32'(n), 32'd5);
        chk("R9", "no second command", 32'(cs_seen), 32'd0);
        chk("R9", "fields kept", rd_data, fields(2'd3, 3'd0, 13'h0, 4'd2));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule